// File: doc/BRIEF.md
# UART Line Engine

This block turns bytes into asynchronous serial frames and turns incoming serial frames back into bytes. A 10-bit line control word sets the character format (7 or 8 data bits, parity off/even/odd, one or two stop bits) and turns the transmitter and receiver on or off. It can also hold the transmit line low to send a break. A 10-bit divisor sets the line rate to 921600/(DIV+1). The bytes to send come from an external transmit buffer through a valid/ready pair. Each received character is handed to an external receive buffer as a 10-bit word. That word holds the data together with a parity-error flag and a framing-error flag.

The oversampling clock runs at 16 times the base rate. It is made from the functional clock by a phase accumulator, so any functional clock frequency at or above 16 × 921600 can be used. A new divisor is held pending until the current oversample period ends. A status byte shows that pending state and the synchronised level of the CTS input. The register file, the FIFOs and the interrupt logic are in a neighbouring block.

Top module: `uart_line_engine`

## Requirements
- R1: After reset, txd is 1, rx_valid is 0, status is 0x00, and tx_ready is 0 while line_ctrl is 0.
- R2: The transmit line idles at 1. A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then stop bits at 1. txd goes low on the cycle after a tx_valid/tx_ready handshake.
- R3: Every bit after the start bit lasts exactly 16 × (DIV+1) oversample ticks. The oversample tick rate is 16 × BASE_BAUD, derived from CLK_HZ.
- R4: line_ctrl bit 2 set selects 8 data bits; clear selects 7. With 7 bits, only tx_data[6:0] is sent, and bit 7 of the received word reads 0.
- R5: line_ctrl bit 4 enables a parity bit. line_ctrl bit 5 set selects odd parity and clear selects even parity, counted over the data bits in use.
- R6: line_ctrl bit 3 set sends two stop bits. The receiver then checks both stop bits.
- R7: line_ctrl bit 0 enables the transmitter; when it is clear, tx_ready is 0 and txd stays 1. line_ctrl bit 1 enables the receiver; when it is clear, incoming frames produce no rx_valid.
- R8: rx_valid is a one-cycle pulse. rx_word holds data in [7:0], the parity-error flag in [8] and the framing-error flag in [9].
- R9: A 0 sampled at the middle of any expected stop bit sets the framing-error flag of that character.
- R10: line_ctrl bit 9 forces txd to 0 from the next cycle for as long as it is set.
- R11: status[4] follows cts_in through a two-flop synchroniser. status bits other than 4 and 5 read 0.
- R12: After a divisor write, status[5] reads 1 until the current oversample period of the old divisor ends. The new divisor then takes effect and status[5] returns to 0.
- R13: A low pulse on rxd that is gone by the start bit's midpoint (8 ticks) is rejected, with no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ctrl | input | 10 | Line control word (bits 0,1,2,3,4,5,9 used) |
| div_wr | input | 1 | Divisor write strobe |
| div_value | input | 10 | Divisor value DIV |
| tx_valid | input | 1 | Transmit buffer has a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Byte taken when high together with tx_valid |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| cts_in | input | 1 | Clear-to-send level (asynchronous) |
| rx_valid | output | 1 | Received word strobe |
| rx_word | output | 10 | {frame error, parity error, data} |
| status | output | 8 | [4] CTS level, [5] divisor update pending |

## Verification
The bench sets CLK_HZ to 29,491,200, which is exactly 32 × 921600. With that value the accumulator produces an oversample tick every second clock with no fractional jitter. Every bit boundary after the start bit then falls on a known clock, so the bench can sample at mid-bit and measure one bit's width to the clock (96 clocks at DIV=2). Divisors 0 to 3 keep each frame to a few hundred clocks. This makes room for every data/parity/stop combination in loopback, plus hand-driven frames with parity errors, framing errors, and a start glitch.

// File: rtl/uart_line_pkg.sv
package uart_line_pkg;

    localparam int unsigned OSR    = 16;
    localparam int unsigned SUB_W  = $clog2(OSR);
    localparam int unsigned CTRL_W = 10;
    localparam int unsigned DIV_W  = 10;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    // control word bit positions
    localparam int unsigned CB_TX_ON  = 0;
    localparam int unsigned CB_RX_ON  = 1;
    localparam int unsigned CB_WIDE   = 2;
    localparam int unsigned CB_TWO_SB = 3;
    localparam int unsigned CB_PAR_ON = 4;
    localparam int unsigned CB_ODD    = 5;
    localparam int unsigned CB_BREAK  = 9;

    // status byte bit positions
    localparam int unsigned SB_CTS  = 4;
    localparam int unsigned SB_PEND = 5;

    typedef struct packed {
        logic brk;
        logic odd;
        logic par_on;
        logic two_sb;
        logic wide;
        logic rx_on;
        logic tx_on;
    } line_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } frame_ph_t;

    typedef struct packed {
        logic              frame_err;
        logic              par_err;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

    function automatic line_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        line_cfg_t c;
        c.tx_on  = w[CB_TX_ON];
        c.rx_on  = w[CB_RX_ON];
        c.wide   = w[CB_WIDE];
        c.two_sb = w[CB_TWO_SB];
        c.par_on = w[CB_PAR_ON];
        c.odd    = w[CB_ODD];
        c.brk    = w[CB_BREAK];
        return c;
    endfunction

    // parity bit value over the active data bits
    function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic wide,
                                     input logic odd);
        logic [BYTE_W-1:0] m;
        m = wide ? d : {1'b0, d[BYTE_W-2:0]};
        return (^m) ^ odd;
    endfunction

    function automatic logic [CNT_W-1:0] last_idx(input logic wide);
        return wide ? CNT_W'(BYTE_W - 1) : CNT_W'(BYTE_W - 2);
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_line_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 24_000_000,
    parameter int unsigned BASE_BAUD = 921_600,
    parameter int unsigned DIV_INIT  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_data,
    output logic             os_tick,
    output logic             div_pend
);
    localparam int unsigned STEP  = BASE_BAUD * OSR;
    localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc, sum;
    logic             base_tick;
    logic [DIV_W-1:0] cnt, act_div, shd_div;

    assign sum       = acc + STEP_V;
    assign base_tick = (sum >= MOD_V);
    assign os_tick   = base_tick && (cnt == act_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            cnt      <= '0;
            act_div  <= DIV_W'(DIV_INIT);
            shd_div  <= DIV_W'(DIV_INIT);
            div_pend <= 1'b0;
        end else begin
            acc <= base_tick ? (sum - MOD_V) : sum;
            if (base_tick) begin
                if (cnt == act_div) begin
                    cnt <= '0;
                    if (div_pend) begin
                        act_div  <= shd_div;
                        div_pend <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (div_wr) begin
                shd_div  <= div_data;
                div_pend <= 1'b1;
            end
        end
    end

    // R12
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> div_pend);

endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_line_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              tx_on,
    input  logic              brk,
    input  logic              wide,
    input  logic              two_sb,
    input  logic              par_on,
    input  logic              odd,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

    frame_ph_t         ph;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              par_q;
    logic              take;
    logic              line_now;

    assign tx_ready = (ph == PH_IDLE) && tx_on;
    assign take     = tx_valid && tx_ready;

    always_comb begin
        case (ph)
            PH_IDLE:  line_now = !take;
            PH_START: line_now = 1'b0;
            PH_DATA:  line_now = sh[0];
            PH_PAR:   line_now = par_q;
            default:  line_now = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= '0;
            par_q <= 1'b0;
            txd   <= 1'b1;
        end else begin
            txd <= brk ? 1'b0 : line_now;
            if (ph == PH_IDLE) begin
                if (take) begin
                    sh    <= tx_data;
                    par_q <= par_bit(tx_data, wide, odd);
                    sub   <= '0;
                    ph    <= PH_START;
                end
            end else if (os_tick) begin
                sub <= sub + 1'b1;
                if (sub == SUB_LAST) begin
                    case (ph)
                        PH_START: begin
                            ph   <= PH_DATA;
                            bitn <= '0;
                        end
                        PH_DATA: begin
                            sh   <= sh >> 1;
                            bitn <= bitn + 1'b1;
                            if (bitn == last_idx(wide)) begin
                                bitn <= '0;
                                ph   <= par_on ? PH_PAR : PH_STOP;
                            end
                        end
                        PH_PAR: begin
                            ph   <= PH_STOP;
                            bitn <= '0;
                        end
                        PH_STOP: begin
                            if (two_sb && bitn == '0) bitn <= 1'b1;
                            else                      ph   <= PH_IDLE;
                        end
                        default: ph <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !brk) |=> !txd);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && !tx_valid && !brk) |=> txd);

    // R10
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        brk |=> !txd);

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_line_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     os_tick,
    input  logic     rx_on,
    input  logic     wide,
    input  logic     two_sb,
    input  logic     par_on,
    input  logic     odd,
    input  logic     rxd,
    output logic     rx_valid,
    output rx_word_t rx_word
);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

    logic              s1, s2;
    frame_ph_t         ph;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              pe, fe;
    logic              fe_now;

    assign fe_now = fe | !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= 1'b1;
            s2       <= 1'b1;
            ph       <= PH_IDLE;
            sub      <= '0;
            bitn     <= '0;
            sh       <= '0;
            pe       <= 1'b0;
            fe       <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            s1       <= rxd;
            s2       <= s1;
            rx_valid <= 1'b0;
            if (!rx_on) begin
                ph <= PH_IDLE;
            end else if (os_tick) begin
                case (ph)
                    PH_IDLE: begin
                        if (!s2) begin
                            ph  <= PH_START;
                            sub <= '0;
                        end
                    end
                    PH_START: begin
                        if (sub == SUB_MID) begin
                            if (!s2) begin
                                ph   <= PH_DATA;
                                sub  <= '0;
                                bitn <= '0;
                                sh   <= '0;
                                pe   <= 1'b0;
                                fe   <= 1'b0;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: begin
                        if (sub == SUB_LAST) begin
                            sub <= '0;
                            case (ph)
                                PH_DATA: begin
                                    sh[bitn] <= s2;
                                    bitn     <= bitn + 1'b1;
                                    if (bitn == last_idx(wide)) begin
                                        bitn <= '0;
                                        ph   <= par_on ? PH_PAR : PH_STOP;
                                    end
                                end
                                PH_PAR: begin
                                    pe   <= (s2 != par_bit(sh, wide, odd));
                                    bitn <= '0;
                                    ph   <= PH_STOP;
                                end
                                default: begin
                                    if (two_sb && bitn == '0) begin
                                        fe   <= fe_now;
                                        bitn <= 1'b1;
                                    end else begin
                                        rx_valid <= 1'b1;
                                        rx_word  <= {fe_now, pe, sh};
                                        ph       <= PH_IDLE;
                                    end
                                end
                            endcase
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R8
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_on |=> !rx_valid);

endmodule

// File: rtl/uart_line_engine.sv
module uart_line_engine
    import uart_line_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 24_000_000,
    parameter int unsigned BASE_BAUD = 921_600,
    parameter int unsigned DIV_INIT  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] line_ctrl,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_in,
    output logic              rx_valid,
    output logic [9:0]        rx_word,
    output logic [7:0]        status
);
    line_cfg_t cfg;
    logic      os_tick;
    logic      div_pend;
    logic      cts_q1, cts_q2;
    rx_word_t  rx_w;
    logic      unused_ctrl_bits;

    assign cfg              = decode_ctrl(line_ctrl);
    assign unused_ctrl_bits = ^line_ctrl[8:6];

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_q1 <= 1'b0;
            cts_q2 <= 1'b0;
        end else begin
            cts_q1 <= cts_in;
            cts_q2 <= cts_q1;
        end
    end

    always_comb begin
        status          = '0;
        status[SB_CTS]  = cts_q2;
        status[SB_PEND] = div_pend;
    end

    uart_baud_gen #(
        .CLK_HZ   (CLK_HZ),
        .BASE_BAUD(BASE_BAUD),
        .DIV_INIT (DIV_INIT)
    ) u_baud (
        .clk     (clk),
        .rst     (rst),
        .div_wr  (div_wr),
        .div_data(div_value),
        .os_tick (os_tick),
        .div_pend(div_pend)
    );

    uart_tx_ser u_tx (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .tx_on   (cfg.tx_on),
        .brk     (cfg.brk),
        .wide    (cfg.wide),
        .two_sb  (cfg.two_sb),
        .par_on  (cfg.par_on),
        .odd     (cfg.odd),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_ready(tx_ready),
        .txd     (txd)
    );

    uart_rx_deser u_rx (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .rx_on   (cfg.rx_on),
        .wide    (cfg.wide),
        .two_sb  (cfg.two_sb),
        .par_on  (cfg.par_on),
        .odd     (cfg.odd),
        .rxd     (rxd),
        .rx_valid(rx_valid),
        .rx_word (rx_w)
    );

    assign rx_word = rx_w;

    // R11
    status_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (status[3:0] == 4'h0) && (status[7:6] == 2'b00));

endmodule

// File: tb/sim_uart_line_engine.sv
module sim_uart_line_engine;

    localparam int unsigned TB_CLK_HZ = 29_491_200;

    // {ctrl[9:0], div[9:0], data[7:0]}
    localparam logic [27:0] VEC [8] = '{
        {10'h007, 10'd0, 8'hA5},   // 8N1
        {10'h017, 10'd0, 8'h3C},   // 8E1
        {10'h037, 10'd1, 8'h3C},   // 8O1
        {10'h003, 10'd0, 8'hD5},   // 7N1
        {10'h01B, 10'd2, 8'h4B},   // 7E2
        {10'h03F, 10'd0, 8'hFF},   // 8O2
        {10'h00F, 10'd3, 8'h00},   // 8N2
        {10'h033, 10'd1, 8'h7E}    // 7O1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] line_ctrl = '0;
    logic       div_wr = 1'b0;
    logic [9:0] div_value = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       txd;
    logic       rxd_w;
    logic       cts_in = 1'b0;
    logic       rx_valid;
    logic [9:0] rx_word;
    logic [7:0] status;
    logic       lb_sel = 1'b0;
    logic       drv_rxd = 1'b1;

    int         checks = 0;
    int         fails = 0;
    int         got_cnt = 0;
    logic [9:0] last_word = '0;
    int         cur_div = 7;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign rxd_w = lb_sel ? txd : drv_rxd;

    uart_line_engine #(.CLK_HZ(TB_CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .line_ctrl(line_ctrl), .div_wr(div_wr),
        .div_value(div_value), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd_w), .cts_in(cts_in),
        .rx_valid(rx_valid), .rx_word(rx_word), .status(status)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            got_cnt   = got_cnt + 1;
            last_word = rx_word;
        end
    end

    function automatic int bp();
        return 32 * (cur_div + 1);
    endfunction

    function automatic int nbits(input logic [9:0] c);
        return c[2] ? 8 : 7;
    endfunction

    function automatic int frame_len(input logic [9:0] c);
        return 1 + nbits(c) + int'(c[4]) + (c[3] ? 2 : 1);
    endfunction

    function automatic logic [11:0] frame_bits(input logic [9:0] c, input logic [7:0] d);
        logic [11:0] b;
        logic [7:0]  m;
        b    = '1;
        b[0] = 1'b0;
        for (int k = 0; k < nbits(c); k++) b[1+k] = d[k];
        m = c[2] ? d : {1'b0, d[6:0]};
        if (c[4]) b[1+nbits(c)] = (^m) ^ c[5];
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_div(input int d);
        int lim;
        div_value = 10'(d);
        div_wr    = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        lim = 0;
        while (status[5] && lim < 200) begin
            @(negedge clk);
            lim++;
        end
        cur_div = d;
    endtask

    task automatic send_tx(input logic [7:0] d);
        int lim;
        tx_data  = d;
        tx_valid = 1'b1;
        lim = 0;
        while (!tx_ready && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic grab_tx(input int n, output logic [11:0] got);
        int lim;
        got = '1;
        lim = 0;
        while (txd !== 1'b0 && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        repeat (bp() / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (bp()) @(negedge clk);
            got[k] = txd;
        end
    endtask

    task automatic wait_rx(input int base, output bit seen);
        int lim;
        lim = 0;
        while (got_cnt == base && lim < 4 * bp()) begin
            @(negedge clk);
            lim++;
        end
        seen = (got_cnt != base);
    endtask

    task automatic drive_rx(input logic [9:0] c, input logic [7:0] d,
                            input bit flip_par, input bit low_stop);
        logic [11:0] b;
        b = frame_bits(c, d);
        if (flip_par) b[1+nbits(c)] = ~b[1+nbits(c)];
        if (low_stop) b[1+nbits(c)+int'(c[4])] = 1'b0;
        for (int k = 0; k < frame_len(c); k++) begin
            drv_rxd = b[k];
            repeat (bp()) @(negedge clk);
        end
        drv_rxd = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] got, exp;
        bit          seen;
        int          base, cnt, lows, rdy;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        chk(status == 8'h00, "R1 status", int'(status), 0);
        chk(tx_ready == 1'b0, "R1 tx_ready", int'(tx_ready), 0);

        // R12 divisor pending flag
        div_value = 10'd0;
        div_wr    = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        chk(status[5] == 1'b1, "R12 pending set", int'(status[5]), 1);
        cnt = 0;
        while (status[5] && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt <= 17, "R12 pending clear cycles", cnt, 17);
        cur_div = 0;

        // R11 CTS reflected after two-flop sync
        cts_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(status == 8'h10, "R11 cts high", int'(status), 8'h10);
        cts_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R11 cts low", int'(status), 0);

        // R2 R4 R5 R6 R3: table of formats in loopback
        lb_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [9:0] c;
            logic [7:0] d;
            logic [9:0] ew;
            c = VEC[i][27:18];
            d = VEC[i][7:0];
            line_ctrl = c;
            set_div(int'(VEC[i][17:8]));
            base = got_cnt;
            send_tx(d);
            grab_tx(frame_len(c), got);
            exp = frame_bits(c, d);
            chk(got == exp, $sformatf("R2 R4 R5 R6 tx frame vec %0d", i), int'(got), int'(exp));
            wait_rx(base, seen);
            ew = {2'b00, c[2] ? d : {1'b0, d[6:0]}};
            chk(seen && last_word == ew, $sformatf("R8 R4 loopback word vec %0d", i),
                int'(last_word), int'(ew));
            repeat (2 * bp()) @(negedge clk);
        end

        // R3 exact bit width at DIV=2: data bit 0 high alone
        line_ctrl = 10'h007;
        set_div(2);
        send_tx(8'h01);
        cnt = 0;
        while (txd !== 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
        while (txd === 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (txd === 1'b1 && cnt < 5000) begin @(negedge clk); cnt++; end
        chk(cnt == 96, "R3 bit width clocks", cnt, 96);
        repeat (12 * bp()) @(negedge clk);
        lb_sel = 1'b0;
        set_div(0);

        // R9 framing error on low stop bit
        line_ctrl = 10'h007;
        base = got_cnt;
        drive_rx(10'h007, 8'h5A, 1'b0, 1'b1);
        wait_rx(base, seen);
        chk(seen && last_word == 10'h25A, "R9 frame error word", int'(last_word), 10'h25A);
        repeat (14 * bp()) @(negedge clk);

        // R5 R8 parity error flag
        line_ctrl = 10'h017;
        base = got_cnt;
        drive_rx(10'h017, 8'h3C, 1'b1, 1'b0);
        wait_rx(base, seen);
        chk(seen && last_word == 10'h13C, "R5 R8 parity error word", int'(last_word), 10'h13C);
        repeat (4 * bp()) @(negedge clk);

        // R6 second stop bit low in two-stop mode
        line_ctrl = 10'h00F;
        base = got_cnt;
        drive_rx(10'h007, 8'h81, 1'b0, 1'b0);
        drv_rxd = 1'b0;
        repeat (bp()) @(negedge clk);
        drv_rxd = 1'b1;
        wait_rx(base, seen);
        chk(seen && last_word == 10'h281, "R6 second stop checked", int'(last_word), 10'h281);
        repeat (14 * bp()) @(negedge clk);

        // R13 short start glitch rejected
        line_ctrl = 10'h007;
        base = got_cnt;
        drv_rxd = 1'b0;
        repeat (6) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (3 * bp()) @(negedge clk);
        chk(got_cnt == base, "R13 glitch rejected", got_cnt - base, 0);

        // R7 receiver disabled ignores a frame
        line_ctrl = 10'h005;
        base = got_cnt;
        drive_rx(10'h007, 8'h66, 1'b0, 1'b0);
        repeat (3 * bp()) @(negedge clk);
        chk(got_cnt == base, "R7 rx disabled", got_cnt - base, 0);

        // R7 transmitter disabled
        line_ctrl = 10'h006;
        tx_data   = 8'h55;
        tx_valid  = 1'b1;
        lows = 0;
        rdy  = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
            if (tx_ready) rdy++;
        end
        tx_valid = 1'b0;
        chk(lows == 0, "R7 tx disabled line idle", lows, 0);
        chk(rdy == 0, "R7 tx disabled not ready", rdy, 0);

        // R10 break
        line_ctrl = 10'h207;
        repeat (2) @(negedge clk);
        chk(txd == 1'b0, "R10 break asserted", int'(txd), 0);
        repeat (100) @(negedge clk);
        chk(txd == 1'b0, "R10 break held", int'(txd), 0);
        line_ctrl = 10'h007;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1, "R10 break released", int'(txd), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule